// File: doc/BRIEF.md
# I2C Host Register Front End

This block sits between an APB bus and the bit-level engine of an I2C master. Software programs the engine by writing a stream of command bytes into a write-only command register. Each write lands in a 32-entry command queue, and the engine drains that queue in the order the bytes were written. Bytes that the engine reads from a target device are pushed into an 8-entry return queue. Software drains the return queue through a read-data register.

A control register and a prescale register together hold the engine enable, the clock-source select, the divider enable and a 13-bit divider. The status register reports the queue levels and three sticky error flags: command overflow, return-queue underflow and bus error. An interrupt-enable register selects which status conditions raise the single block interrupt. Reading status drops the interrupt. Reading the data register clears the sticky flags. Every APB transfer completes with no wait states.

Top module: `i2c_apb_front`

## Requirements
- R1: After a synchronous reset, control, prescale and interrupt-enable read as zero, `irq` is low and status reads 0x02, which means only the command-queue-empty bit is set.
- R2: Control at offset 0x00 reads back bits [7:0]. Bit 7 drives `eng_enable`, bit 6 drives `eng_div_en`, bit 5 drives `eng_clk_sel`, and bits [4:0] are the low divider bits. Prescale at 0x14 holds bits [7:0], and `eng_divisor` equals {prescale, control[4:0]}.
- R3: Each write to offset 0x04 queues pwdata[7:0]. The engine sees the oldest entry on `cmd_data` and removes it with `cmd_pop`. `cmd_empty` is high exactly when the queue holds nothing.
- R4: The command queue holds 32 entries. Status bit 0 is set while it is full. A write while full is dropped and sets the sticky status bit 2, and the 32 held entries stay intact.
- R5: Each `rd_push` queues `rd_data` into an 8-entry return queue, and a push while `rd_full` is high is dropped. A read at 0x08 returns the oldest byte in bits [7:0] and removes it. Status bit 3 is set while the return queue is not empty.
- R6: A read at 0x08 while the return queue is empty returns zero and sets the sticky status bit 4.
- R7: Any read at 0x08 clears the sticky bits 2, 4 and 5. If that read found the queue empty, bit 4 is set again by the same read.
- R8: A pulse on `bus_err_in` sets the sticky status bit 5.
- R9: Interrupt-enable at 0x10 masks status bits [5:0] position for position. `irq` rises when an enabled status bit goes from 0 to 1, stays high until status at 0x0C is read, and then falls.
- R10: `pready` is always high and `pslverr` always low. Reads of offset 0x04 and of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Transfer error, always low |
| cmd_pop | input | 1 | Engine removes the head command |
| cmd_data | output | 8 | Head of the command queue |
| cmd_empty | output | 1 | Command queue empty |
| rd_push | input | 1 | Engine delivers a received byte |
| rd_data | input | 8 | Received byte |
| rd_full | output | 1 | Return queue full |
| bus_err_in | input | 1 | Bus error pulse from the engine |
| eng_enable | output | 1 | Engine enable |
| eng_clk_sel | output | 1 | Clock source select |
| eng_div_en | output | 1 | Divider enable |
| eng_divisor | output | 13 | Combined divider value |
| irq | output | 1 | Block interrupt |

## Verification
The bench fills the command queue one entry past its depth. A design that counted depth wrong, or let the extra write overwrite the oldest entry, would either miss the overflow flag or hand the engine a corrupted order. The return queue gets the same treatment, together with reads of the empty queue. A design that returned stale data there, or failed to raise underflow again on the clearing read itself, would show a wrong status value. The interrupt path is driven with masked and unmasked conditions. This catches an interrupt that ignores the mask, one that drops before the status read, and one that survives it. A sweep over all control values and several prescale values exposes any swapped control field.

// File: rtl/i2cf_pkg.sv
package i2cf_pkg;
    localparam int ADDR_W   = 8;
    localparam int BUS_W    = 32;
    localparam int BYTE_W   = 8;
    localparam int DIV_LO_W = 5;
    localparam int PRE_W    = 8;
    localparam int DIV_W    = PRE_W + DIV_LO_W;
    localparam int STAT_W   = 6;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_RDAT = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_PRE  = 8'h14;

    typedef struct packed {
        logic                enable;
        logic                div_en;
        logic                clk_sel;
        logic [DIV_LO_W-1:0] div_lo;
    } ctrl_t;

    typedef struct packed {
        logic bus_err;
        logic rd_ufl;
        logic rd_ready;
        logic cmd_ovf;
        logic cmd_empty;
        logic cmd_full;
    } stat_t;

    function automatic logic [BUS_W-1:0] widen(input logic [BYTE_W-1:0] v);
        return {{(BUS_W-BYTE_W){1'b0}}, v};
    endfunction
endpackage

// File: rtl/i2cf_fifo.sv
module i2cf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/i2cf_stat.sv
module i2cf_stat
    import i2cf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_full,
    input  logic              cmd_empty,
    input  logic              rd_ready,
    input  logic              set_ovf,
    input  logic              set_ufl,
    input  logic              set_berr,
    input  logic              clr_sticky,
    input  logic [STAT_W-1:0] ien,
    input  logic              stat_rd,
    output stat_t             stat,
    output logic              irq
);
    logic              ovf_q, ufl_q, berr_q, irq_q;
    logic [STAT_W-1:0] masked, prev_q;
    logic              rise;

    always_comb begin
        stat.cmd_full  = cmd_full;
        stat.cmd_empty = cmd_empty;
        stat.cmd_ovf   = ovf_q;
        stat.rd_ready  = rd_ready;
        stat.rd_ufl    = ufl_q;
        stat.bus_err   = berr_q;
    end

    assign masked = stat & ien;
    assign rise   = |(masked & ~prev_q);
    assign irq    = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ovf_q  <= 1'b0;
            ufl_q  <= 1'b0;
            berr_q <= 1'b0;
            prev_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            ovf_q  <= set_ovf  | (ovf_q  & ~clr_sticky);
            ufl_q  <= set_ufl  | (ufl_q  & ~clr_sticky);
            berr_q <= set_berr | (berr_q & ~clr_sticky);
            prev_q <= masked;
            if (rise)         irq_q <= 1'b1;
            else if (stat_rd) irq_q <= 1'b0;
        end
    end
endmodule

// File: rtl/i2c_apb_front.sv
module i2c_apb_front
    import i2cf_pkg::*;
#(
    parameter int CMD_DEPTH = 32,
    parameter int RD_DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [BUS_W-1:0]  pwdata,
    output logic [BUS_W-1:0]  prdata,
    output logic              pready,
    output logic              pslverr,
    input  logic              cmd_pop,
    output logic [BYTE_W-1:0] cmd_data,
    output logic              cmd_empty,
    input  logic              rd_push,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              rd_full,
    input  logic              bus_err_in,
    output logic              eng_enable,
    output logic              eng_clk_sel,
    output logic              eng_div_en,
    output logic [DIV_W-1:0]  eng_divisor,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [PRE_W-1:0]  pre_q;
    logic [STAT_W-1:0] ien_q;
    stat_t             stat_w;
    logic              acc_wr, acc_rd;
    logic              cmd_wr, rdat_rd, stat_rd;
    logic              cmd_full, rd_empty;
    logic [BYTE_W-1:0] rd_head;
    logic              unused_bits;

    assign acc_wr  = psel && penable && pwrite;
    assign acc_rd  = psel && penable && !pwrite;
    assign cmd_wr  = acc_wr && (paddr == OFS_CMD);
    assign rdat_rd = acc_rd && (paddr == OFS_RDAT);
    assign stat_rd = acc_rd && (paddr == OFS_STAT);
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign unused_bits = ^pwdata[BUS_W-1:BYTE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            pre_q  <= '0;
            ien_q  <= '0;
        end else if (acc_wr) begin
            case (paddr)
                OFS_CTRL: ctrl_q <= ctrl_t'(pwdata[BYTE_W-1:0]);
                OFS_PRE:  pre_q  <= pwdata[PRE_W-1:0];
                OFS_IEN:  ien_q  <= pwdata[STAT_W-1:0];
                default:  ;
            endcase
        end
    end

    i2cf_fifo #(.W(BYTE_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst(rst),
        .push(cmd_wr), .push_data(pwdata[BYTE_W-1:0]),
        .pop(cmd_pop), .head(cmd_data),
        .empty(cmd_empty), .full(cmd_full)
    );

    i2cf_fifo #(.W(BYTE_W), .DEPTH(RD_DEPTH)) u_rd_q (
        .clk(clk), .rst(rst),
        .push(rd_push), .push_data(rd_data),
        .pop(rdat_rd), .head(rd_head),
        .empty(rd_empty), .full(rd_full)
    );

    i2cf_stat u_stat (
        .clk(clk), .rst(rst),
        .cmd_full(cmd_full), .cmd_empty(cmd_empty), .rd_ready(!rd_empty),
        .set_ovf(cmd_wr && cmd_full),
        .set_ufl(rdat_rd && rd_empty),
        .set_berr(bus_err_in),
        .clr_sticky(rdat_rd),
        .ien(ien_q), .stat_rd(stat_rd),
        .stat(stat_w), .irq(irq)
    );

    always_comb begin
        case (paddr)
            OFS_CTRL: prdata = widen(ctrl_q);
            OFS_RDAT: prdata = widen(rd_head);
            OFS_STAT: prdata = widen({2'b00, stat_w});
            OFS_IEN:  prdata = widen({2'b00, ien_q});
            OFS_PRE:  prdata = widen(pre_q);
            default:  prdata = '0;
        endcase
    end

    assign eng_enable  = ctrl_q.enable;
    assign eng_clk_sel = ctrl_q.clk_sel;
    assign eng_div_en  = ctrl_q.div_en;
    assign eng_divisor = {pre_q, ctrl_q.div_lo};
endmodule

// File: rtl/i2c_apb_front_chk.sv
module i2c_apb_front_chk (
    input logic        clk,
    input logic        rst,
    input logic        psel,
    input logic        penable,
    input logic        pwrite,
    input logic [7:0]  paddr,
    input logic [31:0] pwdata,
    input logic [31:0] prdata,
    input logic        bus_err_in,
    input logic        eng_enable,
    input logic        irq,
    input logic [5:0]  stat
);
    logic acc;
    assign acc = psel && penable;

    AST_CTRL_ENABLE: assert property (@(posedge clk) disable iff (rst)
        (acc && pwrite && paddr == 8'h00) |=> (eng_enable == $past(pwdata[7]))); // R2
    AST_CMD_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (acc && pwrite && paddr == 8'h04 && stat[0]) |=> stat[2]); // R4
    AST_UFL_ZERO: assert property (@(posedge clk) disable iff (rst)
        (acc && !pwrite && paddr == 8'h08 && !stat[3]) |-> (prdata == 32'h0)); // R6
    AST_UFL_SET: assert property (@(posedge clk) disable iff (rst)
        (acc && !pwrite && paddr == 8'h08 && !stat[3]) |=> stat[4]); // R6
    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (stat[2] && !(acc && !pwrite && paddr == 8'h08)) |=> stat[2]); // R7
    AST_BUS_ERR: assert property (@(posedge clk) disable iff (rst)
        bus_err_in |=> stat[5]); // R8
    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (irq && !(acc && !pwrite && paddr == 8'h0C)) |=> irq); // R9
endmodule

bind i2c_apb_front i2c_apb_front_chk u_chk (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .bus_err_in(bus_err_in),
    .eng_enable(eng_enable), .irq(irq), .stat(stat_w)
);

// File: tb/test_i2c_apb_front.sv
`timescale 1ns/100ps
module test_i2c_apb_front;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        cmd_pop = 1'b0;
    logic [7:0]  cmd_data;
    logic        cmd_empty;
    logic        rd_push = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        rd_full;
    logic        bus_err_in = 1'b0;
    logic        eng_enable, eng_clk_sel, eng_div_en;
    logic [12:0] eng_divisor;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_apb_front i_i2c_apb_front (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .cmd_pop(cmd_pop), .cmd_data(cmd_data),
        .cmd_empty(cmd_empty), .rd_push(rd_push), .rd_data(rd_data),
        .rd_full(rd_full), .bus_err_in(bus_err_in), .eng_enable(eng_enable),
        .eng_clk_sel(eng_clk_sel), .eng_div_en(eng_div_en),
        .eng_divisor(eng_divisor), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic apb_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        d = prdata;
        if (pready !== 1'b1 || pslverr !== 1'b0) begin
            n_fail++;
            $display("FAIL R10: actual ready=%b err=%b expected ready=1 err=0", pready, pslverr);
        end
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic eng_push(input logic [7:0] b);
        @(negedge clk);
        rd_push = 1'b1; rd_data = b;
        @(negedge clk);
        rd_push = 1'b0;
    endtask

    task automatic berr_pulse();
        @(negedge clk);
        bus_err_in = 1'b1;
        @(negedge clk);
        bus_err_in = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 enable", {31'b0, eng_enable}, 32'h0);
        apb_rd(8'h0C, v); chk("R1 status", v, 32'h02);
        apb_rd(8'h00, v); chk("R1 ctrl", v, 32'h0);
        apb_rd(8'h10, v); chk("R1 ien", v, 32'h0);
        apb_rd(8'h14, v); chk("R1 prescale", v, 32'h0);

        // R10 unmapped and write-only offsets
        apb_rd(8'h18, v); chk("R10 unmapped", v, 32'h0);
        apb_rd(8'h04, v); chk("R10 cmd read", v, 32'h0);

        // R2 full control sweep, prescale varied arithmetically
        for (int c = 0; c < 256; c++) begin
            logic [7:0] p;
            p = 8'((c * 97 + 11) & 255);
            apb_wr(8'h00, 32'(c) | 32'hFFFF_FF00);
            apb_wr(8'h14, {24'h0, p});
            apb_rd(8'h00, v);
            chk("R2 ctrl readback", v, 32'(c));
            chk("R2 fields", {29'b0, eng_enable, eng_div_en, eng_clk_sel},
                {29'b0, 3'(c >> 5)});
            chk("R2 divisor", {19'b0, eng_divisor}, {19'b0, p, 5'(c)});
        end
        apb_wr(8'h00, 32'h0);

        // R3 R4 fill command queue past its depth
        for (int i = 0; i < 33; i++) begin
            apb_wr(8'h04, 32'((i * 29 + 5) & 255));
            if (i == 0) chk("R3 not empty", {31'b0, cmd_empty}, 32'h0);
            if (i == 30) begin
                apb_rd(8'h0C, v); chk("R4 not yet full", v, 32'h0);
            end
            if (i == 31) begin
                apb_rd(8'h0C, v); chk("R4 full no overflow", v, 32'h01);
            end
        end
        apb_rd(8'h0C, v); chk("R4 overflow set", v, 32'h05);
        for (int i = 0; i < 32; i++) begin
            @(negedge clk);
            chk("R3 order", {24'b0, cmd_data}, 32'((i * 29 + 5) & 255));
            cmd_pop = 1'b1;
            @(negedge clk);
            cmd_pop = 1'b0;
        end
        chk("R3 empty after drain", {31'b0, cmd_empty}, 32'h1);
        apb_rd(8'h0C, v); chk("R4 overflow sticky", v, 32'h06);

        // R6 R7 empty data read clears sticky and sets underflow
        apb_rd(8'h08, v); chk("R6 empty read zero", v, 32'h0);
        apb_rd(8'h0C, v); chk("R7 clear then underflow", v, 32'h12);
        eng_push(8'hA5);
        apb_rd(8'h0C, v); chk("R5 ready", v, 32'h1A);
        apb_rd(8'h08, v); chk("R5 byte", v, 32'hA5);
        apb_rd(8'h0C, v); chk("R7 underflow cleared", v, 32'h02);

        // R5 return queue past its depth
        for (int k = 0; k < 9; k++) begin
            eng_push(8'((k * 53 + 1) & 255));
            if (k == 7) chk("R5 full", {31'b0, rd_full}, 32'h1);
        end
        for (int k = 0; k < 8; k++) begin
            apb_rd(8'h08, v);
            chk("R5 order", v, 32'((k * 53 + 1) & 255));
        end
        apb_rd(8'h0C, v); chk("R5 ninth dropped", v, 32'h02);

        // R8 bus error sticky, cleared by data read
        berr_pulse();
        repeat (3) @(negedge clk);
        apb_rd(8'h0C, v); chk("R8 bus error", v, 32'h22);
        apb_rd(8'h08, v);
        apb_rd(8'h0C, v); chk("R7 bus error cleared", v, 32'h12);

        // R9 masked condition leaves irq low
        berr_pulse();
        repeat (4) @(negedge clk);
        chk("R9 masked", {31'b0, irq}, 32'h0);
        apb_rd(8'h08, v);
        apb_wr(8'h10, 32'h20);
        apb_rd(8'h10, v); chk("R9 ien readback", v, 32'h20);
        berr_pulse();
        repeat (3) @(negedge clk);
        chk("R9 irq set", {31'b0, irq}, 32'h1);
        repeat (6) @(negedge clk);
        chk("R9 irq held", {31'b0, irq}, 32'h1);
        apb_rd(8'h0C, v);
        chk("R9 irq cleared", {31'b0, irq}, 32'h0);
        repeat (3) @(negedge clk);
        chk("R9 stays cleared", {31'b0, irq}, 32'h0);
        apb_wr(8'h10, 32'h08);
        eng_push(8'h3C);
        repeat (2) @(negedge clk);
        chk("R9 ready irq", {31'b0, irq}, 32'h1);
        apb_rd(8'h0C, v);
        chk("R9 ready irq cleared", {31'b0, irq}, 32'h0);
        apb_rd(8'h08, v); chk("R5 last byte", v, 32'h3C);

        finish_run();
    end
endmodule